// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a timer peripheral with a parameterised number of independent 32-bit down-counters. Each channel owns a control word, an interval word and a read-only live-count word. All channels share one interrupt-enable word and one interrupt-status word. A single level interrupt output combines every channel whose status flag and enable bit are both set.

A channel is clocked by a tick enable, not by its own clock. The source-select field picks one of two tick inputs supplied from outside. A prescaler then passes only every 2^p-th of those ticks. In periodic mode the channel reloads its interval each time it passes zero. In one-shot mode it stops at zero and clears its own enable. Clearing the enable by software does not stop the count at once: the counter keeps going for two more source ticks. Software therefore waits that long before it reprograms the channel.

The register bus uses word addresses, with a write strobe and read data that is registered. Word 0 holds the interrupt enables and word 1 the interrupt status. Channel n occupies words 4n+4 (control), 4n+5 (interval) and 4n+6 (live count).

Top module: `tick_timer`

## Requirements
- R1: After reset every control, interval, count, interrupt-enable and status word reads 0, and `irq` is 0.
- R2: The interval word reads back the last value written to it. In the control word, bit 0 is enable, bits 3:2 are source select, bits 6:4 are the prescaler and bit 7 is one-shot; these fields read back as written. Bit 1 always reads 0.
- R3: A running periodic channel with interval I behaves as follows on each active tick. The tick at which the counter already holds 0 sets the channel's status bit and reloads I. Every other tick decrements the counter by one. Starting from 0xFFFFFFFF, the next tick gives 0xFFFFFFFE.
- R4: In one-shot mode (bit 7 = 1), the tick at which the counter holds 0 sets the status bit, clears the enable bit and leaves the counter at 0. Later ticks do not change the counter.
- R5: Writing control bit 1 as 1 makes the next active tick copy the interval into the counter.
- R6: Writing 1 to status bit n clears channel n's flag, and writing 0 leaves that flag unchanged.
- R7: `irq` is high exactly when some channel has both its status bit and its interrupt-enable bit set, where enable bit n belongs to channel n.
- R8: After software clears a running channel's enable, the counter still responds to the next two ticks of the selected source, then holds its value.
- R9: Source select 1 takes ticks from `tickIn[1]`; any other value takes ticks from `tickIn[0]`.
- R10: With prescaler p, the channel's counter acts only on every 2^p-th tick of its selected source. The first such tick is the 2^p-th source tick since reset.
- R11: Writes to a live-count word have no effect.
- R12: `rdData` presents the addressed word one clock after the address is applied. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 2 | Tick enables offered to the source select |
| wrEn | input | 1 | Write strobe for the word at `addr` |
| addr | input | AW | Word address |
| wrData | input | CW | Write data |
| rdData | output | CW | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that each tick input is a single-clock enable. They also assume that `addr` names a mapped word, or a harmless unmapped one, whenever `wrEn` is high, and that reset is held for at least one clock edge. The stimulus meets these assumptions in the following way. Every tick is a pulse lasting exactly one clock. Bus writes and tick pulses never overlap. Each scenario starts from a fresh reset, so the prescaler phase counted from reset is known in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CH_IDX_W = 4;

  localparam int CTL_EN    = 0;
  localparam int CTL_RLD   = 1;
  localparam int CTL_SRC   = 2;
  localparam int CTL_PRE   = 4;
  localparam int CTL_ONE   = 7;
  localparam int CTL_WIDTH = 8;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_IRQEN,
    RK_IRQST,
    RK_CTRL,
    RK_INTV,
    RK_VAL
  } regKind_e;

  typedef struct packed {
    logic                wr;
    regKind_e            kind;
    logic [CH_IDX_W-1:0] ch;
  } busCmd_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = 6
) (
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  output busCmd_t       cmd
);
  logic [AW-1:0] off;
  logic [AW-3:0] chN;

  always_comb begin
    cmd.wr   = 1'b0;
    cmd.kind = RK_NONE;
    cmd.ch   = '0;
    off      = addr - AW'(4);
    chN      = off[AW-1:2];
    if (addr == AW'(0)) begin
      cmd.kind = RK_IRQEN;
    end else if (addr == AW'(1)) begin
      cmd.kind = RK_IRQST;
    end else if (addr >= AW'(4) && int'(chN) < NCH) begin
      cmd.ch = CH_IDX_W'(chN);
      case (off[1:0])
        2'd0:    cmd.kind = RK_CTRL;
        2'd1:    cmd.kind = RK_INTV;
        2'd2:    cmd.kind = RK_VAL;
        default: cmd.kind = RK_NONE;
      endcase
    end
    cmd.wr = wrEn && (cmd.kind != RK_NONE);
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW    = 32,
  parameter int PRE_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           tickIn,
  input  logic                 ctrlWr,
  input  logic                 intvWr,
  input  logic [CW-1:0]        wrData,
  output logic [CTL_WIDTH-1:0] ctlOut,
  output logic [CW-1:0]        intvOut,
  output logic [CW-1:0]        cntOut,
  output logic                 expire
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic             en, relPend, oneShot;
  logic [1:0]       src;
  logic [PRE_W-1:0] pres;
  logic [1:0]       grace;
  logic [DIV_W-1:0] preCnt, divMask;
  logic [CW-1:0]    intv, cnt;
  logic             srcTick, chTick, active;

  assign srcTick = (src == 2'd1) ? tickIn[1] : tickIn[0];
  assign divMask = ~({DIV_W{1'b1}} << pres);
  assign chTick  = srcTick && ((preCnt & divMask) == divMask);
  assign active  = en || (grace != 2'd0);
  assign expire  = active && chTick && !relPend && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en      <= 1'b0;
      relPend <= 1'b0;
      oneShot <= 1'b0;
      src     <= '0;
      pres    <= '0;
      grace   <= '0;
      preCnt  <= '0;
      intv    <= '0;
      cnt     <= '0;
    end else begin
      if (srcTick) preCnt <= preCnt + 1'b1;
      if (intvWr) intv <= wrData;
      if (active && chTick) begin
        relPend <= 1'b0;
        if (relPend) cnt <= intv;
        else if (cnt == '0) begin
          if (oneShot) en <= 1'b0;
          else cnt <= intv;
        end else cnt <= cnt - 1'b1;
      end
      if (grace != 2'd0 && srcTick) grace <= grace - 2'd1;
      if (ctrlWr) begin
        en      <= wrData[CTL_EN];
        src     <= wrData[CTL_SRC +: 2];
        pres    <= wrData[CTL_PRE +: PRE_W];
        oneShot <= wrData[CTL_ONE];
        if (wrData[CTL_RLD]) relPend <= 1'b1;
        if (wrData[CTL_EN]) grace <= 2'd0;
        else if (en) grace <= 2'd2;
      end
    end
  end

  assign ctlOut  = {oneShot, pres, src, 1'b0, en};
  assign intvOut = intv;
  assign cntOut  = cnt;

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (active && chTick && !relPend && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  a_r3_reload_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !oneShot) |=> (cnt == $past(intv)));
  a_r4_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (expire && oneShot && !ctrlWr) |=> (!en && cnt == '0));
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(active && chTick) |=> $stable(cnt));
  a_r8_grace_bound: assert property (@(posedge clk) disable iff (!rstN)
    grace <= 2'd2);
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    tickIn,
  input  busCmd_t       cmd,
  input  logic [CW-1:0] wrData,
  output logic [CW-1:0] rdData,
  output logic          irq
);
  logic [NCH-1:0]       ieReg, stReg, expVec, clrMask;
  logic [CTL_WIDTH-1:0] chCtl  [NCH];
  logic [CW-1:0]        chIntv [NCH];
  logic [CW-1:0]        chCnt  [NCH];
  logic [CTL_WIDTH-1:0] selCtl;
  logic [CW-1:0]        selIntv, selCnt, rdNext;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tmr_chan #(.CW(CW)) i_chan (
      .clk     (clk),
      .rstN    (rstN),
      .tickIn  (tickIn),
      .ctrlWr  (cmd.wr && cmd.kind == RK_CTRL && cmd.ch == CH_IDX_W'(g)),
      .intvWr  (cmd.wr && cmd.kind == RK_INTV && cmd.ch == CH_IDX_W'(g)),
      .wrData  (wrData),
      .ctlOut  (chCtl[g]),
      .intvOut (chIntv[g]),
      .cntOut  (chCnt[g]),
      .expire  (expVec[g])
    );
  end

  assign clrMask = (cmd.wr && cmd.kind == RK_IRQST) ? wrData[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieReg  <= '0;
      stReg  <= '0;
      rdData <= '0;
    end else begin
      if (cmd.wr && cmd.kind == RK_IRQEN) ieReg <= wrData[NCH-1:0];
      stReg  <= (stReg & ~clrMask) | expVec;
      rdData <= rdNext;
    end
  end

  always_comb begin
    selCtl  = '0;
    selIntv = '0;
    selCnt  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cmd.ch == CH_IDX_W'(i)) begin
        selCtl  = chCtl[i];
        selIntv = chIntv[i];
        selCnt  = chCnt[i];
      end
    end
    case (cmd.kind)
      RK_IRQEN: rdNext = CW'(ieReg);
      RK_IRQST: rdNext = CW'(stReg);
      RK_CTRL:  rdNext = CW'(selCtl);
      RK_INTV:  rdNext = selIntv;
      RK_VAL:   rdNext = selCnt;
      default:  rdNext = '0;
    endcase
  end

  assign irq = |(stReg & ieReg);

  a_r6_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wr && cmd.kind == RK_IRQST && expVec == '0)
      |=> ((stReg & $past(wrData[NCH-1:0])) == '0));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (!(cmd.wr && cmd.kind == RK_IRQST)) |=> ((stReg & $past(stReg)) == $past(stReg)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    tickIn,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wrData,
  output logic [CW-1:0] rdData,
  output logic          irq
);
  busCmd_t cmd;

  tmr_ctrl #(.NCH(NCH), .AW(AW)) i_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .cmd  (cmd)
  );

  tmr_dp #(.NCH(NCH), .CW(CW)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tickIn (tickIn),
    .cmd    (cmd),
    .wrData (wrData),
    .rdData (rdData),
    .irq    (irq)
  );
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  tickIn = 2'b00;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  localparam logic [5:0] A_IE = 6'd0, A_IS = 6'd1;
  localparam logic [5:0] A_C0 = 6'd4, A_I0 = 6'd5, A_V0 = 6'd6;
  localparam logic [5:0] A_C1 = 6'd8, A_I1 = 6'd9, A_V1 = 6'd10;

  // interval, ticks applied after start, expected count, expected status
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV][4] = '{
    '{32'd5, 32'd1,  32'd5, 32'd0},
    '{32'd5, 32'd4,  32'd2, 32'd0},
    '{32'd5, 32'd6,  32'd0, 32'd0},
    '{32'd5, 32'd7,  32'd5, 32'd1},
    '{32'd3, 32'd10, 32'd2, 32'd1},
    '{32'd0, 32'd3,  32'd0, 32'd1},
    '{32'd1, 32'd2,  32'd0, 32'd0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdData;
  endtask

  task automatic ticks(int n, logic [1:0] m);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickIn = m;
      @(negedge clk);
      tickIn = 2'b00;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;

    // R1 reset state
    doReset();
    rd(A_C0, v); check("R1 ctrl0", v, 0);
    rd(A_I0, v); check("R1 intv0", v, 0);
    rd(A_V0, v); check("R1 count0", v, 0);
    rd(A_IE, v); check("R1 irq enable", v, 0);
    rd(A_IS, v); check("R1 status", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(6'd3, v); check("R12 unmapped", v, 0);

    // R2 field readback
    wr(A_I0, 32'hDEADBEEF);
    rd(A_I0, v); check("R2 interval", v, 32'hDEADBEEF);
    wr(A_C0, 32'h7C);
    rd(A_C0, v); check("R2 ctrl fields", v, 32'h7C);

    // R3 periodic vectors, R12 read latency
    for (int k = 0; k < NV; k++) begin
      doReset();
      wr(A_IE, 32'h1);
      wr(A_I0, VEC[k][0]);
      wr(A_C0, 32'h03);
      ticks(int'(VEC[k][1]), 2'b01);
      rd(A_V0, v); check($sformatf("R3 R12 count vec%0d", k), v, VEC[k][2]);
      rd(A_IS, v); check($sformatf("R3 status vec%0d", k), v, VEC[k][3]);
      check($sformatf("R7 irq vec%0d", k), {31'd0, irq}, VEC[k][3]);
    end

    // R5 reload strobe and decrement from all ones
    doReset();
    wr(A_I0, 32'hFFFFFFFF);
    wr(A_C0, 32'h03);
    rd(A_C0, v); check("R5 reload reads 0", v, 32'h01);
    rd(A_V0, v); check("R5 no load before tick", v, 0);
    ticks(1, 2'b01);
    rd(A_V0, v); check("R5 load on tick", v, 32'hFFFFFFFF);
    ticks(1, 2'b01);
    rd(A_V0, v); check("R3 decrement from max", v, 32'hFFFFFFFE);

    // R4 one-shot, R6 and R7 interrupt handling
    doReset();
    wr(A_IE, 32'h1);
    wr(A_I0, 32'd2);
    wr(A_C0, 32'h83);
    ticks(3, 2'b01);
    rd(A_V0, v); check("R4 count before expiry", v, 0);
    rd(A_IS, v); check("R4 no status yet", v, 0);
    ticks(1, 2'b01);
    rd(A_IS, v); check("R4 status set", v, 1);
    rd(A_C0, v); check("R4 enable cleared", v, 32'h80);
    ticks(2, 2'b01);
    rd(A_V0, v); check("R4 count held", v, 0);
    wr(A_IS, 32'h0);
    rd(A_IS, v); check("R6 write 0 keeps", v, 1);
    wr(A_IE, 32'h0);
    check("R7 masked", {31'd0, irq}, 0);
    wr(A_IE, 32'h1);
    check("R7 unmasked", {31'd0, irq}, 1);
    wr(A_IS, 32'h1);
    rd(A_IS, v); check("R6 write 1 clears", v, 0);
    check("R7 cleared", {31'd0, irq}, 0);

    // R8 disable grace, R11 count read-only
    doReset();
    wr(A_I0, 32'd100);
    wr(A_C0, 32'h03);
    ticks(2, 2'b01);
    rd(A_V0, v); check("R8 running", v, 99);
    wr(A_C0, 32'h00);
    ticks(2, 2'b01);
    rd(A_V0, v); check("R8 two grace ticks", v, 97);
    ticks(2, 2'b01);
    rd(A_V0, v); check("R8 stopped", v, 97);
    wr(A_V0, 32'h1234);
    rd(A_V0, v); check("R11 write ignored", v, 97);

    // R9 source select on channel 1
    doReset();
    wr(A_I1, 32'd50);
    wr(A_C1, 32'h07);
    ticks(3, 2'b01);
    rd(A_V1, v); check("R9 other source ignored", v, 0);
    ticks(1, 2'b10);
    rd(A_V1, v); check("R9 load from input 1", v, 50);
    ticks(1, 2'b10);
    rd(A_V1, v); check("R9 count from input 1", v, 49);
    rd(A_V0, v); check("R9 channel 0 untouched", v, 0);

    // R10 prescaler p=2
    doReset();
    wr(A_I0, 32'd100);
    wr(A_C0, 32'h23);
    ticks(3, 2'b01);
    rd(A_V0, v); check("R10 no tick before 4th", v, 0);
    ticks(1, 2'b01);
    rd(A_V0, v); check("R10 4th source tick", v, 100);
    ticks(8, 2'b01);
    rd(A_V0, v); check("R10 divided count", v, 98);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule